// File: doc/BRIEF.md
# Ingress Packet Preclassifier with Priority Queues

The preclassifier sits between a group of Ethernet MAC ports and a downstream buffering stage on an oversubscribed line card. Packets arrive as a stream of wide beats tagged with the input port number. The block accepts a beat on every cycle and never stalls the ports. The first beat of each packet carries the whole header window, and a fixed rule set reads its EtherType, IPv4 header and layer-4 ports. From these fields the block chooses one of four classes: control, real-time, best effort or drop.

There are three class FIFOs: control, real-time and best effort. The drop class has no FIFO. Admission is decided once per packet, on its first beat. A refused packet is discarded in full at the input, and the downstream path never sees any part of it. Best-effort traffic is refused first, as soon as its FIFO backs up past a watermark. Control and real-time packets are refused only when their own FIFO has no room for a maximum-length packet.

Toward the buffering stage, whole packets leave in strict priority: control, then real-time, then best effort. A saturating counter block keeps received, sent and dropped packet counts for each port and class. It has a combinational read port and a synchronous clear for one port.

Top module: `pkt_preclass`

## Requirements
- R1: The class is decided on the first beat only. Byte k of a beat is `in_data[8k+7:8k]`. EtherType is bytes 12..13 (big-endian). For IPv4, the version/IHL byte is 14, DSCP is byte 15 bits 7:2, and protocol is byte 23. The source port is bytes 34..35 and the destination port is bytes 36..37; these are used only when IHL is 5. The control class (code 0) is assigned to EtherType 0x0806, to IPv4 protocol 89, to TCP (6) with either port equal to 179, and to UDP (17) with destination port 3784 or 3785.
- R2: An IPv4 packet that is not control goes to real-time (code 1) if its DSCP is 46, or if it is UDP with a destination port from 16384 to 32767 inclusive.
- R3: The drop class (code 3) is assigned to EtherType values below 0x0600, and to EtherType 0x0800 whose version is not 4 or whose IHL is below 5. Every other packet is best effort (code 2). This includes IPv4 with IHL above 5, whose layer-4 ports are not examined.
- R4: A best-effort packet is refused when, at its first beat, the best-effort FIFO holds at least `BE_LIMIT` beats.
- R5: A control or real-time packet is refused only when, at its first beat, its FIFO holds more than `DEPTH-MAX_BEATS` beats. A FIFO never holds more than `DEPTH` beats.
- R6: A packet is never presented downstream if it is in the drop class or if it was refused. None of its beats appears on the output.
- R7: At each packet boundary, the output picks the highest-priority non-empty FIFO (control, then real-time, then best effort). It then stays on that FIFO until the end-of-packet beat is accepted, so packets are never interleaved. `ds_sop` is high exactly on the first beat of each output packet.
- R8: Every admitted beat leaves in the order it arrived within its class, with its data, end-of-packet flag and port unchanged. A beat that has been offered but not accepted in mid-packet stays on the output.
- R9: Counter `stat_kind` 0 (received) counts every first beat at its port and decided class. Counter 1 (sent) counts each accepted end-of-packet beat at its port and class. Counter 2 (dropped) counts each refused or drop-class packet. Kind 3 reads 0. All counters are 0 after reset.
- R10: Counters stop at all-ones instead of wrapping.
- R11: `clr_en` zeroes all counters of `clr_port` on the next edge. A clear takes priority over an increment in the same cycle, and the other ports are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present; accepted every cycle |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_port | input | PORT_W | Input port number |
| in_data | input | 8*BEAT_BYTES | Beat bytes |
| ds_valid | output | 1 | Output beat present |
| ds_ready | input | 1 | Downstream accepts the beat |
| ds_sop | output | 1 | First beat of output packet |
| ds_eop | output | 1 | Last beat of output packet |
| ds_port | output | PORT_W | Port the packet arrived on |
| ds_class | output | 2 | Class of the output packet |
| ds_data | output | 8*BEAT_BYTES | Output beat bytes |
| stat_port | input | PORT_W | Counter read: port |
| stat_cls | input | 2 | Counter read: class |
| stat_kind | input | 2 | Counter read: 0 received, 1 sent, 2 dropped |
| stat_value | output | CNT_W | Selected counter value |
| clr_en | input | 1 | Clear the counters of one port |
| clr_port | input | PORT_W | Port to clear |

## Verification
On every cycle, the bound assertions check these properties:
- No FIFO ever exceeds its depth.
- Every refusal had a cause: the best-effort watermark for best-effort packets, or a nearly full FIFO for control and real-time packets.
- No drop-class beat reaches the output.
- The output class stays fixed within a packet.
- A mid-packet beat is held while `ds_ready` is low.

Some behaviour only the bench scenarios can show:
- The header rules at their edges: the port range limits 16383, 16384, 32767 and 32768, and IHL above 5.
- The strict-priority order after a backlog builds up.
- Exact counter values after saturation and after a port clear.
- End-to-end beat contents under random backpressure.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    CLS_CTRL = 2'd0,
    CLS_RT   = 2'd1,
    CLS_BE   = 2'd2,
    CLS_DROP = 2'd3
  } cls_e;

  localparam int HDR_BYTES = 38;
  localparam logic [15:0] ET_ARP   = 16'h0806;
  localparam logic [15:0] ET_IPV4  = 16'h0800;
  localparam logic [15:0] ET_MINTY = 16'h0600;
  localparam logic [7:0]  PR_TCP   = 8'd6;
  localparam logic [7:0]  PR_UDP   = 8'd17;
  localparam logic [7:0]  PR_OSPF  = 8'd89;

  // Fixed header rules; byte k of the window sits at h[8k +: 8].
  function automatic cls_e hdr_class(input logic [8*HDR_BYTES-1:0] h);
    logic [15:0] et, sp, dp;
    logic [7:0]  vi, proto;
    logic [5:0]  dscp;
    logic        l4;
    et    = {h[8*12 +: 8], h[8*13 +: 8]};
    vi    = h[8*14 +: 8];
    dscp  = h[8*15+2 +: 6];
    proto = h[8*23 +: 8];
    sp    = {h[8*34 +: 8], h[8*35 +: 8]};
    dp    = {h[8*36 +: 8], h[8*37 +: 8]};
    l4    = (vi[3:0] == 4'd5);
    if (et == ET_ARP) return CLS_CTRL;
    if (et < ET_MINTY) return CLS_DROP;
    if (et != ET_IPV4) return CLS_BE;
    if (vi[7:4] != 4'd4 || vi[3:0] < 4'd5) return CLS_DROP;
    if (proto == PR_OSPF) return CLS_CTRL;
    if (l4 && proto == PR_TCP && (sp == 16'd179 || dp == 16'd179)) return CLS_CTRL;
    if (l4 && proto == PR_UDP && (dp == 16'd3784 || dp == 16'd3785)) return CLS_CTRL;
    if (dscp == 6'd46) return CLS_RT;
    if (l4 && proto == PR_UDP && dp[15:14] == 2'b01) return CLS_RT;
    return CLS_BE;
  endfunction
endpackage

// File: rtl/prc_fifo.sv
module prc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          nonempty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdata    = mem[rp];
  assign nonempty = (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= adv(wp);
      if (pop)  rp <= adv(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/prc_egress.sv
module prc_egress (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] nonempty,
  input  logic [2:0] head_eop,
  input  logic       ds_ready,
  output logic       ds_valid,
  output logic       ds_sop,
  output logic [1:0] cur_cls,
  output logic       fire
);
  logic       mid;
  logic [1:0] sel_q, pick;

  always_comb begin
    if (nonempty[0])      pick = 2'd0;
    else if (nonempty[1]) pick = 2'd1;
    else                  pick = 2'd2;
  end

  assign cur_cls  = mid ? sel_q : pick;
  assign ds_valid = mid ? nonempty[sel_q] : (|nonempty);
  assign ds_sop   = !mid;
  assign fire     = ds_valid && ds_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid   <= 1'b0;
      sel_q <= 2'd0;
    end else if (fire) begin
      mid   <= !head_eop[cur_cls];
      sel_q <= cur_cls;
    end
  end
endmodule

// File: rtl/prc_stats.sv
module prc_stats #(
  parameter int NPORTS = 4,
  parameter int CNT_W  = 48,
  parameter int PORT_W = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [PORT_W-1:0] rx_port,
  input  logic [1:0]        rx_cls,
  input  logic              tx_en,
  input  logic [PORT_W-1:0] tx_port,
  input  logic [1:0]        tx_cls,
  input  logic              dr_en,
  input  logic [PORT_W-1:0] dr_port,
  input  logic [1:0]        dr_cls,
  input  logic              clr_en,
  input  logic [PORT_W-1:0] clr_port,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [1:0]        rd_cls,
  input  logic [1:0]        rd_kind,
  output logic [CNT_W-1:0]  rd_value
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] ctr [NPORTS][4][4];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [PORT_W-1:0] PID = PORT_W'(p);
    for (genvar c = 0; c < 4; c++) begin : g_cls
      localparam logic [1:0] CID = 2'(c);
      for (genvar k = 0; k < 4; k++) begin : g_kind
        if (k == 3) begin : g_none
          assign ctr[p][c][k] = '0;
        end else begin : g_cnt
          logic             hit;
          logic [CNT_W-1:0] q;
          if (k == 0) begin : g_rx
            assign hit = rx_en && rx_port == PID && rx_cls == CID;
          end else if (k == 1) begin : g_tx
            assign hit = tx_en && tx_port == PID && tx_cls == CID;
          end else begin : g_dr
            assign hit = dr_en && dr_port == PID && dr_cls == CID;
          end
          always_ff @(posedge clk) begin
            if (!rst_n)                        q <= '0;
            else if (clr_en && clr_port == PID) q <= '0;
            else if (hit)                      q <= bump(q);
          end
          assign ctr[p][c][k] = q;
        end
      end
    end
  end

  assign rd_value = ctr[rd_port][rd_cls][rd_kind];
endmodule

// File: rtl/pkt_preclass.sv
module pkt_preclass
  import prc_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int BEAT_BYTES = 64,
  parameter int DEPTH      = 16,
  parameter int MAX_BEATS  = 4,
  parameter int BE_LIMIT   = 8,
  parameter int CNT_W      = 48,
  localparam int PORT_W    = $clog2(NPORTS),
  localparam int BEAT_W    = 8 * BEAT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [PORT_W-1:0] in_port,
  input  logic [BEAT_W-1:0] in_data,
  output logic              ds_valid,
  input  logic              ds_ready,
  output logic              ds_sop,
  output logic              ds_eop,
  output logic [PORT_W-1:0] ds_port,
  output logic [1:0]        ds_class,
  output logic [BEAT_W-1:0] ds_data,
  input  logic [PORT_W-1:0] stat_port,
  input  logic [1:0]        stat_cls,
  input  logic [1:0]        stat_kind,
  output logic [CNT_W-1:0]  stat_value,
  input  logic              clr_en,
  input  logic [PORT_W-1:0] clr_port
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = BEAT_W + 1 + PORT_W;
  localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - MAX_BEATS);
  localparam logic [CW-1:0] BE_MARK  = CW'(BE_LIMIT);

  // Named internal events, also used by the checker.
  cls_e            sop_cls;
  logic            sop_evt, sop_admit, ev_sop_drop, ev_tx;
  logic [1:0]      ev_cls;
  logic [3*CW-1:0] fcnt_flat;

  logic            pk_active;
  logic [1:0]      pk_cls;
  logic            beat_push;
  logic [1:0]      push_cls;

  logic [CW-1:0]   fcnt [3];
  logic [FW-1:0]   fhead [3];
  logic [2:0]      f_ne, f_eop, f_push, f_pop;
  logic            eg_fire;

  assign sop_cls = hdr_class(in_data[8*HDR_BYTES-1:0]);
  assign sop_evt = in_valid && in_sop;
  assign ev_cls  = sop_cls;

  always_comb begin
    case (sop_cls)
      CLS_CTRL: sop_admit = (fcnt[0] <= ROOM_MAX);
      CLS_RT:   sop_admit = (fcnt[1] <= ROOM_MAX);
      CLS_BE:   sop_admit = (fcnt[2] <  BE_MARK);
      default:  sop_admit = 1'b0;
    endcase
  end

  assign ev_sop_drop = sop_evt && !sop_admit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_active <= 1'b0;
      pk_cls    <= 2'd0;
    end else if (sop_evt) begin
      pk_active <= sop_admit && !in_eop;
      pk_cls    <= sop_cls;
    end else if (in_valid && in_eop) begin
      pk_active <= 1'b0;
    end
  end

  assign beat_push = in_valid && (in_sop ? sop_admit : pk_active);
  assign push_cls  = in_sop ? sop_cls : pk_cls;

  for (genvar i = 0; i < 3; i++) begin : g_q
    assign f_push[i] = beat_push && push_cls == 2'(i);
    assign f_pop[i]  = eg_fire && ds_class == 2'(i);
    prc_fifo #(.W(FW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(f_push[i]), .wdata({in_port, in_eop, in_data}),
      .pop(f_pop[i]), .rdata(fhead[i]),
      .count(fcnt[i]), .nonempty(f_ne[i])
    );
    assign f_eop[i]            = fhead[i][BEAT_W];
    assign fcnt_flat[i*CW +: CW] = fcnt[i];
  end

  prc_egress u_egress (
    .clk(clk), .rst_n(rst_n), .nonempty(f_ne), .head_eop(f_eop),
    .ds_ready(ds_ready), .ds_valid(ds_valid), .ds_sop(ds_sop),
    .cur_cls(ds_class), .fire(eg_fire)
  );

  logic [FW-1:0] out_word;
  assign out_word = (ds_class == 2'd3) ? fhead[2] : fhead[ds_class];
  assign ds_data  = out_word[BEAT_W-1:0];
  assign ds_eop   = out_word[BEAT_W];
  assign ds_port  = out_word[FW-1 -: PORT_W];
  assign ev_tx    = eg_fire && ds_eop;

  prc_stats #(.NPORTS(NPORTS), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .rx_en(sop_evt), .rx_port(in_port), .rx_cls(sop_cls),
    .tx_en(ev_tx), .tx_port(ds_port), .tx_cls(ds_class),
    .dr_en(ev_sop_drop), .dr_port(in_port), .dr_cls(sop_cls),
    .clr_en(clr_en), .clr_port(clr_port),
    .rd_port(stat_port), .rd_cls(stat_cls), .rd_kind(stat_kind),
    .rd_value(stat_value)
  );
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int DEPTH     = 16,
  parameter int MAX_BEATS = 4,
  parameter int BE_LIMIT  = 8,
  parameter int BEAT_W    = 512,
  parameter int CW        = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ds_valid,
  input logic            ds_ready,
  input logic            ds_sop,
  input logic            ds_eop,
  input logic [1:0]      ds_class,
  input logic [BEAT_W-1:0] ds_data,
  input logic [3*CW-1:0] fcnt_flat,
  input logic            ev_sop_drop,
  input logic [1:0]      ev_cls
);
  logic [CW-1:0] c_ctrl, c_rt, c_be;
  assign c_ctrl = fcnt_flat[0 +: CW];
  assign c_rt   = fcnt_flat[CW +: CW];
  assign c_be   = fcnt_flat[2*CW +: CW];

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    c_ctrl <= CW'(DEPTH) && c_rt <= CW'(DEPTH) && c_be <= CW'(DEPTH));

  a_r4_be_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sop_drop && ev_cls == 2'd2) |-> c_be >= CW'(BE_LIMIT));

  a_r5_ctrl_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sop_drop && ev_cls == 2'd0) |-> c_ctrl > CW'(DEPTH - MAX_BEATS));

  a_r5_rt_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sop_drop && ev_cls == 2'd1) |-> c_rt > CW'(DEPTH - MAX_BEATS));

  a_r6_no_drop_out: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> ds_class != 2'd3);

  a_r7_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && ds_ready && !ds_eop) |=> (!ds_sop && ds_class == $past(ds_class)));

  a_r7_sop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && ds_ready && ds_eop) |=> ds_sop);

  a_r8_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready && !ds_sop) |=>
      (ds_valid && $stable(ds_data) && $stable(ds_class) && $stable(ds_eop)));
endmodule

bind pkt_preclass prc_checker #(
  .DEPTH(DEPTH), .MAX_BEATS(MAX_BEATS), .BE_LIMIT(BE_LIMIT),
  .BEAT_W(BEAT_W), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ds_valid(ds_valid), .ds_ready(ds_ready),
  .ds_sop(ds_sop), .ds_eop(ds_eop), .ds_class(ds_class), .ds_data(ds_data),
  .fcnt_flat(fcnt_flat), .ev_sop_drop(ev_sop_drop), .ev_cls(ev_cls)
);

// File: tb/sim_pkt_preclass.sv
module sim_pkt_preclass;
  localparam int DEP = 16, MAXB = 4, BEL = 8, SAT = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [1:0] in_port = 0;
  logic [511:0] in_data = '0;
  logic ds_ready = 0;
  logic ds_valid, ds_sop, ds_eop;
  logic [1:0] ds_port, ds_class;
  logic [511:0] ds_data;
  logic [1:0] stat_port = 0, stat_cls = 0, stat_kind = 0;
  logic [4:0] stat_value;
  logic clr_en = 0;
  logic [1:0] clr_port = 0;

  int total = 0, bad = 0;
  string phase = "R9";
  bit done = 0;

  always #4 clk = ~clk;

  pkt_preclass #(.CNT_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_port(in_port), .in_data(in_data),
    .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_sop(ds_sop),
    .ds_eop(ds_eop), .ds_port(ds_port), .ds_class(ds_class),
    .ds_data(ds_data), .stat_port(stat_port), .stat_cls(stat_cls),
    .stat_kind(stat_kind), .stat_value(stat_value),
    .clr_en(clr_en), .clr_port(clr_port)
  );

  // ---------------- reference model ----------------
  typedef struct { logic [511:0] d; bit eop; int port; } beat_t;
  beat_t mq[3][$];
  int mcnt[4][4][4];
  bit mmid, mact;
  int msel, mcls;

  function automatic int byte_at(logic [511:0] d, int i);
    return int'(d[8*i +: 8]);
  endfunction

  function automatic int ref_cls(logic [511:0] d);
    int et, ver, ihl, pr, dscp, sp, dp;
    bit ports;
    et = byte_at(d, 12) * 256 + byte_at(d, 13);
    ver = byte_at(d, 14) / 16;
    ihl = byte_at(d, 14) % 16;
    dscp = byte_at(d, 15) / 4;
    pr = byte_at(d, 23);
    sp = byte_at(d, 34) * 256 + byte_at(d, 35);
    dp = byte_at(d, 36) * 256 + byte_at(d, 37);
    if (et == 'h0806) return 0;
    if (et < 'h0600) return 3;
    if (et != 'h0800) return 2;
    if (ver != 4 || ihl < 5) return 3;
    ports = (ihl == 5);
    if (pr == 89) return 0;
    if (ports && pr == 6 && (sp == 179 || dp == 179)) return 0;
    if (ports && pr == 17 && (dp == 3784 || dp == 3785)) return 0;
    if (dscp == 46) return 1;
    if (ports && pr == 17 && dp >= 16384 && dp <= 32767) return 1;
    return 2;
  endfunction

  function automatic int sat_up(int v);
    return (v >= SAT) ? SAT : v + 1;
  endfunction

  function automatic void model_out(output bit v, output int cur);
    if (mmid) begin
      cur = msel;
      v = mq[msel].size() > 0;
    end else begin
      cur = (mq[0].size() > 0) ? 0 : (mq[1].size() > 0) ? 1 : 2;
      v = mq[0].size() + mq[1].size() + mq[2].size() > 0;
    end
  endfunction

  always @(posedge clk) begin
    bit v, fire, adm;
    int cur, c;
    beat_t hd, nb;
    if (!rst_n) begin
      for (int q = 0; q < 3; q++) mq[q].delete();
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++)
          for (int j = 0; j < 4; j++) mcnt[p][k][j] = 0;
      mmid = 0; mact = 0; msel = 0; mcls = 0;
    end else begin
      model_out(v, cur);
      fire = v && ds_ready;
      if (fire) hd = mq[cur][0];
      nb.d = in_data; nb.eop = in_eop; nb.port = int'(in_port);
      adm = 0;
      if (in_valid && in_sop) begin
        c = ref_cls(in_data);
        if (c == 2) adm = mq[2].size() < BEL;
        else if (c < 2) adm = mq[c].size() <= DEP - MAXB;
        mcnt[in_port][c][0] = sat_up(mcnt[in_port][c][0]);
        if (!adm) mcnt[in_port][c][2] = sat_up(mcnt[in_port][c][2]);
      end
      if (fire) begin
        void'(mq[cur].pop_front());
        if (hd.eop) mcnt[hd.port][cur][1] = sat_up(mcnt[hd.port][cur][1]);
        mmid = !hd.eop;
        msel = cur;
      end
      if (in_valid && in_sop) begin
        if (adm) mq[c].push_back(nb);
        mact = adm && !in_eop;
        mcls = c;
      end else if (in_valid && mact) begin
        mq[mcls].push_back(nb);
        if (in_eop) mact = 0;
      end
      if (clr_en)
        for (int k = 0; k < 4; k++)
          for (int j = 0; j < 4; j++) mcnt[clr_port][k][j] = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit v;
    int cur;
    beat_t hd;
    if (rst_n && !done) begin
      model_out(v, cur);
      chk(ds_valid == v, phase, "ds_valid", ds_valid, v);
      if (v && ds_valid) begin
        hd = mq[cur][0];
        chk(ds_class == cur, phase, "ds_class", ds_class, cur);
        chk(ds_sop == !mmid, "R7", "ds_sop", ds_sop, !mmid);
        chk(ds_data == hd.d, "R8", "ds_data", ds_data[63:0], hd.d[63:0]);
        chk(ds_eop == hd.eop && ds_port == hd.port, "R8", "eop/port",
            {ds_eop, ds_port}, {hd.eop, 2'(hd.port)});
      end
      chk(stat_value == mcnt[stat_port][stat_cls][stat_kind], "R9", "stat_value",
          stat_value, mcnt[stat_port][stat_cls][stat_kind]);
      {stat_port, stat_cls, stat_kind} = {stat_port, stat_cls, stat_kind} + 6'd1;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [511:0] mk(int et, int vi, int tos, int pr, int sp, int dp, int tag);
    logic [511:0] d;
    d = '0;
    d[8*0 +: 8] = 8'(tag); d[8*6 +: 8] = 8'(tag >> 8);
    d[8*12 +: 8] = 8'(et >> 8); d[8*13 +: 8] = 8'(et);
    d[8*14 +: 8] = 8'(vi); d[8*15 +: 8] = 8'(tos); d[8*23 +: 8] = 8'(pr);
    d[8*34 +: 8] = 8'(sp >> 8); d[8*35 +: 8] = 8'(sp);
    d[8*36 +: 8] = 8'(dp >> 8); d[8*37 +: 8] = 8'(dp);
    d[8*50 +: 32] = 32'(tag * 7919);
    return d;
  endfunction

  int tagc = 1;
  task automatic send(int port, logic [511:0] hdr, int nb);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (b == 0); in_eop = (b == nb - 1);
      in_port = 2'(port);
      in_data = (b == 0) ? hdr : {16{32'(tagc * 131 + b)}};
    end
    tagc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0;
    end
  endtask

  task automatic peek(int p, int c, int k, int exp, string req);
    @(negedge clk);
    #2;
    stat_port = 2'(p); stat_cls = 2'(c); stat_kind = 2'(k);
    #1;
    chk(stat_value == exp, req, "counter peek", stat_value, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    @(negedge clk); #1;
    chk(ds_valid == 0, "R9", "reset ds_valid", ds_valid, 0);
    peek(1, 2, 0, 0, "R9");

    ds_ready = 1;
    phase = "R1";
    send(0, mk('h0806, 0, 0, 0, 0, 0, tagc), 2);
    send(0, mk('h0800, 'h45, 0, 89, 0, 0, tagc), 1);
    send(1, mk('h0800, 'h45, 0, 6, 179, 80, tagc), 3);
    send(1, mk('h0800, 'h45, 0, 6, 80, 179, tagc), 1);
    send(2, mk('h0800, 'h45, 0, 17, 9, 3784, tagc), 2);
    send(3, mk('h0800, 'h45, 0, 17, 9, 3785, tagc), 1);
    idle(4);
    peek(0, 0, 0, 2, "R1");
    phase = "R2";
    send(0, mk('h0800, 'h45, 46 << 2, 6, 1, 2, tagc), 2);
    send(1, mk('h0800, 'h45, 0, 17, 1, 16384, tagc), 1);
    send(1, mk('h0800, 'h45, 0, 17, 1, 32767, tagc), 1);
    send(1, mk('h0800, 'h45, 0, 17, 1, 16383, tagc), 1);
    send(1, mk('h0800, 'h45, 0, 17, 1, 32768, tagc), 1);
    idle(4);
    peek(1, 1, 0, 2, "R2");
    phase = "R3";
    send(2, mk('h86dd, 0, 0, 0, 0, 0, tagc), 1);
    send(2, mk('h0800, 'h46, 0, 17, 1, 3784, tagc), 2);
    send(2, mk('h0800, 'h45, 0, 6, 1, 80, tagc), 1);
    idle(4);
    peek(2, 2, 0, 3, "R3");
    phase = "R6";
    send(3, mk('h05dc, 0, 0, 0, 0, 0, tagc), 2);
    send(3, mk('h0800, 'h44, 0, 0, 0, 0, tagc), 1);
    send(3, mk('h0800, 'h65, 0, 0, 0, 0, tagc), 3);
    idle(4);
    peek(3, 3, 2, 3, "R6");

    // R4/R5: backpressure floods
    ds_ready = 0;
    phase = "R4";
    for (int i = 0; i < 5; i++) send(1, mk('h0800, 'h45, 0, 6, 5, 80, tagc), 3);
    idle(2);
    peek(1, 2, 2, 2, "R4");
    phase = "R5";
    for (int i = 0; i < 5; i++) send(0, mk('h0806, 0, 0, 0, 0, 0, tagc), 4);
    for (int i = 0; i < 5; i++) send(2, mk('h0800, 'h45, 46 << 2, 17, 1, 2, tagc), 4);
    idle(2);
    peek(0, 0, 2, 1, "R5");
    peek(2, 1, 2, 1, "R5");
    // R7: control drains first although best effort arrived first
    phase = "R7";
    @(negedge clk); #1;
    chk(ds_valid && ds_class == 2'd0 && ds_sop, "R7", "priority head",
        {ds_valid, ds_class}, 3'b100);
    ds_ready = 1;
    idle(60);

    // random mix with random backpressure
    phase = "R8";
    for (int i = 0; i < 120; i++) begin
      int k = $urandom_range(0, 5);
      int p = $urandom_range(0, 3);
      int n = $urandom_range(1, 4);
      logic [511:0] h;
      case (k)
        0: h = mk('h0806, 0, 0, 0, 0, 0, tagc);
        1: h = mk('h0800, 'h45, 0, 17, 1, 20000, tagc);
        2: h = mk('h0800, 'h45, 0, 6, 1, 443, tagc);
        3: h = mk('h0300, 0, 0, 0, 0, 0, tagc);
        4: h = mk('h0800, 'h45, 0, 6, 179, 1, tagc);
        default: h = mk('h0800, 'h45, 46 << 2, 6, 1, 1, tagc);
      endcase
      fork
        send(p, h, n);
        begin
          @(negedge clk);
          ds_ready = ($urandom_range(0, 3) != 0);
        end
      join
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    ds_ready = 1;
    idle(80);

    // R10: saturation
    phase = "R10";
    for (int i = 0; i < 40; i++) send(2, mk('h0800, 'h45, 0, 6, 1, 80, tagc), 1);
    idle(6);
    peek(2, 2, 0, SAT, "R10");
    peek(2, 2, 1, SAT, "R10");

    // R11: clear one port
    phase = "R11";
    @(negedge clk);
    clr_en = 1; clr_port = 2;
    @(negedge clk);
    clr_en = 0;
    peek(2, 2, 0, 0, "R11");
    peek(2, 2, 1, 0, "R11");
    peek(0, 0, 0, mcnt[0][0][0], "R11");
    chk(mcnt[0][0][0] > 0, "R11", "other port kept", mcnt[0][0][0], 1);
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule